// File: doc/BRIEF.md
# I2C Status and Interrupt Flags

This block keeps the status byte and the interrupt request of an I2C controller that can act as bus master or as addressed slave. It does not touch the bus itself. The bus engine hands it one-cycle event strobes and a few mode levels:

- detected START and STOP conditions;
- SCL falling edges, together with the index of the current clock within the byte;
- SDA sample strobes, with the level the master drives and the level read back;
- an own-address match and the R/W bit that came with it;
- software requests for a start or a repeated start.

The CPU side supplies write strobes for the status and control registers, the written status byte, and the interrupt-enable level of the control register.

From these inputs the block sets and clears eight status bits. Each bit updates on the clock edge where its strobe is high. The interrupt request is the interrupt-pending bit gated by the enable. Arbitration loss is raised by any of five distinct conditions. Arbitration-lost and interrupt-pending are sticky: only a status write with a 0 in that position clears them. A hardware set in the same cycle beats that clear, so no event is dropped.

Top module: `i2c_stat_flags`

## Requirements
- R1: After reset the status byte reads 0x81. Bit 7 is transfer-complete, bit 6 addressed-as-slave, bit 5 bus-busy, bit 4 arbitration-lost, bit 3 reserved (always 0), bit 2 slave-read/write, bit 1 interrupt-pending, bit 0 received-acknowledge. irq is 0.
- R2: Transfer-complete clears on an SCL fall with bit_cnt = 1, the first clock of a byte. It stays 0 through later clocks and sets on an SCL fall with bit_cnt = 9.
- R3: Received-acknowledge takes sda_in at the SCL fall with bit_cnt = 9 (0 = ACK, 1 = NACK).
- R4: Bus-busy sets one cycle after ev_start and clears one cycle after ev_stop.
- R5: addr_match sets addressed-as-slave and loads slave-read/write from rw_bit. cr_wr clears addressed-as-slave. A match in the same cycle as cr_wr leaves the bit set.
- R6: Arbitration-lost sets on bit_smp when mst_mode=1, tx_mode=1, 1 ≤ bit_cnt ≤ 8, sda_drv=1 and sda_in=0. It does not set when sda_drv=0.
- R7: Arbitration-lost sets on bit_smp when mst_mode=1, tx_mode=0, bit_cnt=9, sda_drv=1 and sda_in=0.
- R8: Arbitration-lost sets on req_start while bus-busy is 1, and on req_rstart while mst_mode=0.
- R9: Arbitration-lost sets on ev_stop while mst_mode=1 and stop_req=0. It does not set when stop_req=1 or when mst_mode=0.
- R10: A status write (sr_wr) with bit 4 = 0 clears arbitration-lost, and with bit 1 = 0 clears interrupt-pending. Writing 1 to these bits has no effect. A status write never changes bits 7, 5, 2 or 0.
- R11: Interrupt-pending sets on the bit_cnt = 9 SCL fall, on addr_match with rw_bit = 0, and on any arbitration loss. It does not set on addr_match with rw_bit = 1.
- R12: irq equals interrupt-pending AND ien.
- R13: When a set event and a clearing status write fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_start | input | 1 | START condition detected |
| ev_stop | input | 1 | STOP condition detected |
| scl_fall | input | 1 | SCL falling-edge strobe |
| bit_smp | input | 1 | SDA sample strobe (SCL high) |
| bit_cnt | input | 4 | Clock index within the byte, 1..9 |
| sda_in | input | 1 | SDA level sampled back |
| sda_drv | input | 1 | SDA level the master drives |
| mst_mode | input | 1 | Controller is master |
| tx_mode | input | 1 | Controller is transmitting |
| stop_req | input | 1 | Master has requested a STOP |
| req_start | input | 1 | Software start request strobe |
| req_rstart | input | 1 | Software repeated-start request strobe |
| addr_match | input | 1 | Calling address equals own address |
| rw_bit | input | 1 | R/W bit of the calling address |
| sr_wr | input | 1 | CPU write to status register |
| sr_wdata | input | 8 | Data written to status register |
| cr_wr | input | 1 | CPU write to control register |
| ien | input | 1 | Interrupt enable from control register |
| status | output | 8 | Status byte |
| irq | output | 1 | Interrupt request |

## Verification
The embedded assertions check the following on every cycle:

- each edge of bus-busy has its START or STOP cause;
- the sticky flags fall only after a matching zero write;
- any arbitration cause is followed by arbitration-lost and interrupt-pending, even when a clear arrives in the same cycle;
- addressed-as-slave falls only after a control write.

The directed scenarios show the rest:

- which of the five arbitration triggers fire and which near-miss patterns do not;
- the exact bit-index windows of the transfer-complete and acknowledge captures;
- that writing ones or touching unrelated bits leaves the byte intact;
- the gating of irq by ien.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
  localparam int unsigned SB_TCF  = 7;
  localparam int unsigned SB_AAS  = 6;
  localparam int unsigned SB_BUSY = 5;
  localparam int unsigned SB_AL   = 4;
  localparam int unsigned SB_RSVD = 3;
  localparam int unsigned SB_SRW  = 2;
  localparam int unsigned SB_IIF  = 1;
  localparam int unsigned SB_RXAK = 0;
  localparam logic [7:0] SB_RESET = 8'h81;

  typedef struct packed {
    logic tx_mis;
    logic ack_mis;
    logic start_busy;
    logic rstart_slave;
    logic stop_unreq;
  } arb_cause_t;

  // Software clears a sticky bit by writing a zero in its position.
  function automatic logic wr_zero(logic wr, logic [7:0] d, int unsigned pos);
    return wr && !d[pos];
  endfunction

  // Next value of a flag where a hardware set beats a clear.
  function automatic logic set_wins(logic q, logic set, logic clr);
    return set ? 1'b1 : (clr ? 1'b0 : q);
  endfunction
endpackage

// File: rtl/i2c_stat_sticky.sv
module i2c_stat_sticky #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  import i2c_stat_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= set_wins(q, set, clr);
  end

  // R13: a set event always leaves the flag high, whatever the clear
  a_r13_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q);
  // A fall needs a clear and no set in the cycle before
  a_r10_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(q) |-> $past(clr && !set));
endmodule

// File: rtl/i2c_stat_arb.sv
module i2c_stat_arb #(
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned DATA_BITS = 8
) (
  input  logic                        bit_smp,
  input  logic [CNT_W-1:0]            bit_cnt,
  input  logic                        mst_mode,
  input  logic                        tx_mode,
  input  logic                        sda_drv,
  input  logic                        sda_in,
  input  logic                        req_start,
  input  logic                        req_rstart,
  input  logic                        busy,
  input  logic                        ev_stop,
  input  logic                        stop_req,
  output i2c_stat_pkg::arb_cause_t    cause,
  output logic                        lost
);
  localparam logic [CNT_W-1:0] ACK_IDX = CNT_W'(DATA_BITS + 1);

  function automatic logic in_data(logic [CNT_W-1:0] c);
    return (c != '0) && (c <= CNT_W'(DATA_BITS));
  endfunction

  logic overdriven;
  assign overdriven = bit_smp && mst_mode && sda_drv && !sda_in;

  always_comb begin
    cause.tx_mis       = overdriven && tx_mode && in_data(bit_cnt);
    cause.ack_mis      = overdriven && !tx_mode && (bit_cnt == ACK_IDX);
    cause.start_busy   = req_start && busy;
    cause.rstart_slave = req_rstart && !mst_mode;
    cause.stop_unreq   = ev_stop && mst_mode && !stop_req;
  end

  assign lost = |cause;
endmodule

// File: rtl/i2c_stat_xfer.sv
module i2c_stat_xfer #(
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned DATA_BITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_fall,
  input  logic [CNT_W-1:0] bit_cnt,
  input  logic             sda_in,
  output logic             byte_done,
  output logic             tcf,
  output logic             rxak
);
  localparam logic [CNT_W-1:0] LAST_IDX  = CNT_W'(DATA_BITS + 1);
  localparam logic [CNT_W-1:0] FIRST_IDX = CNT_W'(1);

  logic byte_begin;
  assign byte_begin = scl_fall && (bit_cnt == FIRST_IDX);
  assign byte_done  = scl_fall && (bit_cnt == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcf  <= 1'b1;
      rxak <= 1'b1;
    end else begin
      if (byte_done)       tcf <= 1'b1;
      else if (byte_begin) tcf <= 1'b0;
      if (byte_done)       rxak <= sda_in;
    end
  end

  a_r2_tcf_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tcf) |-> $past(scl_fall && bit_cnt == LAST_IDX));
  a_r2_tcf_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tcf) |-> $past(scl_fall && bit_cnt == FIRST_IDX));
  a_r3_rxak_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !scl_fall |=> $stable(rxak));
endmodule

// File: rtl/i2c_stat_flags.sv
module i2c_stat_flags #(
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned DATA_BITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_start,
  input  logic             ev_stop,
  input  logic             scl_fall,
  input  logic             bit_smp,
  input  logic [CNT_W-1:0] bit_cnt,
  input  logic             sda_in,
  input  logic             sda_drv,
  input  logic             mst_mode,
  input  logic             tx_mode,
  input  logic             stop_req,
  input  logic             req_start,
  input  logic             req_rstart,
  input  logic             addr_match,
  input  logic             rw_bit,
  input  logic             sr_wr,
  input  logic [7:0]       sr_wdata,
  input  logic             cr_wr,
  input  logic             ien,
  output logic [7:0]       status,
  output logic             irq
);
  import i2c_stat_pkg::*;

  logic       busy, aas, al, iif, srw, tcf, rxak;
  logic       byte_done, arb_lost;
  logic       clr_al, clr_iif, iif_set, slave_rx_hit;
  arb_cause_t cause;

  i2c_stat_xfer #(.CNT_W(CNT_W), .DATA_BITS(DATA_BITS)) u_xfer (
    .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall), .bit_cnt(bit_cnt),
    .sda_in(sda_in), .byte_done(byte_done), .tcf(tcf), .rxak(rxak)
  );

  i2c_stat_arb #(.CNT_W(CNT_W), .DATA_BITS(DATA_BITS)) u_arb (
    .bit_smp(bit_smp), .bit_cnt(bit_cnt), .mst_mode(mst_mode),
    .tx_mode(tx_mode), .sda_drv(sda_drv), .sda_in(sda_in),
    .req_start(req_start), .req_rstart(req_rstart), .busy(busy),
    .ev_stop(ev_stop), .stop_req(stop_req), .cause(cause), .lost(arb_lost)
  );

  assign clr_al       = wr_zero(sr_wr, sr_wdata, SB_AL);
  assign clr_iif      = wr_zero(sr_wr, sr_wdata, SB_IIF);
  assign slave_rx_hit = addr_match && !rw_bit;
  assign iif_set      = byte_done || slave_rx_hit || arb_lost;

  i2c_stat_sticky #(.RST_VAL(1'b0)) u_busy (
    .clk(clk), .rst_n(rst_n), .set(ev_start), .clr(ev_stop), .q(busy));
  i2c_stat_sticky #(.RST_VAL(1'b0)) u_aas (
    .clk(clk), .rst_n(rst_n), .set(addr_match), .clr(cr_wr), .q(aas));
  i2c_stat_sticky #(.RST_VAL(1'b0)) u_al (
    .clk(clk), .rst_n(rst_n), .set(arb_lost), .clr(clr_al), .q(al));
  i2c_stat_sticky #(.RST_VAL(1'b0)) u_iif (
    .clk(clk), .rst_n(rst_n), .set(iif_set), .clr(clr_iif), .q(iif));

  always_ff @(posedge clk) begin
    if (!rst_n)          srw <= 1'b0;
    else if (addr_match) srw <= rw_bit;
  end

  always_comb begin
    status          = '0;
    status[SB_TCF]  = tcf;
    status[SB_AAS]  = aas;
    status[SB_BUSY] = busy;
    status[SB_AL]   = al;
    status[SB_RSVD] = 1'b0;
    status[SB_SRW]  = srw;
    status[SB_IIF]  = iif;
    status[SB_RXAK] = rxak;
  end

  assign irq = iif && ien;

  a_r4_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[SB_BUSY]) |-> $past(ev_start));
  a_r4_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[SB_BUSY]) |-> $past(ev_stop));
  a_r5_aas_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[SB_AAS]) |-> $past(cr_wr));
  a_r5_srw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_match |=> $stable(status[SB_SRW]));
  a_r11_arb_irq: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |=> (status[SB_AL] && status[SB_IIF]));
  a_r10_iif_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[SB_IIF]) |-> $past(sr_wr && !sr_wdata[SB_IIF]));
  a_r1_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr |=> !status[SB_RSVD]);
endmodule

// File: tb/tb_i2c_stat_flags.sv
module tb_i2c_stat_flags;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_start, ev_stop, scl_fall, bit_smp, sda_in, sda_drv;
  logic mst_mode, tx_mode, stop_req, req_start, req_rstart;
  logic addr_match, rw_bit, sr_wr, cr_wr, ien;
  logic [3:0] bit_cnt;
  logic [7:0] sr_wdata;
  logic [7:0] status;
  logic irq;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  i2c_stat_flags dut (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
    .scl_fall(scl_fall), .bit_smp(bit_smp), .bit_cnt(bit_cnt),
    .sda_in(sda_in), .sda_drv(sda_drv), .mst_mode(mst_mode),
    .tx_mode(tx_mode), .stop_req(stop_req), .req_start(req_start),
    .req_rstart(req_rstart), .addr_match(addr_match), .rw_bit(rw_bit),
    .sr_wr(sr_wr), .sr_wdata(sr_wdata), .cr_wr(cr_wr), .ien(ien),
    .status(status), .irq(irq)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic idle();
    ev_start = 0; ev_stop = 0; scl_fall = 0; bit_smp = 0; bit_cnt = 0;
    sda_in = 1; sda_drv = 1; stop_req = 0; req_start = 0; req_rstart = 0;
    addr_match = 0; rw_bit = 0; sr_wr = 0; sr_wdata = 8'h00; cr_wr = 0;
  endtask

  // Strobes set by the caller are held for one edge, then released.
  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic sr_write(logic [7:0] d);
    sr_wr = 1; sr_wdata = d; step();
  endtask

  task automatic fall(logic [3:0] n, logic sda);
    scl_fall = 1; bit_cnt = n; sda_in = sda; step();
  endtask

  task automatic t_reset();
    chk("R1 reset status", status, 8'h81);
    chk("R1 reset irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_byte();
    ien = 0;
    fall(4'd1, 1'b1);
    chk("R2 tcf clears at first fall", {7'b0, status[7]}, 8'h00);
    fall(4'd5, 1'b1);
    chk("R2 tcf low mid-byte", {7'b0, status[7]}, 8'h00);
    fall(4'd9, 1'b0);
    chk("R2/R3/R11 ninth fall", status, 8'h82);
    chk("R12 irq masked", {7'b0, irq}, 8'h00);
    ien = 1; #1;
    chk("R12 irq enabled", {7'b0, irq}, 8'h01);
    sr_write(8'hFD);
    chk("R10 iif cleared, others kept", status, 8'h80);
    chk("R12 irq drops", {7'b0, irq}, 8'h00);
    fall(4'd1, 1'b0); fall(4'd9, 1'b1);
    chk("R3 nack captured", status, 8'h83);
    sr_write(8'h00);
  endtask

  task automatic t_busy();
    mst_mode = 0;
    ev_start = 1; step();
    chk("R4 busy set", status, 8'hA1);
    ev_stop = 1; step();
    chk("R4/R9 busy clear, slave stop no loss", status, 8'h81);
  endtask

  task automatic t_slave();
    mst_mode = 0;
    addr_match = 1; rw_bit = 0; step();
    chk("R5/R11 slave rx match", status, 8'hC3);
    cr_wr = 1; step();
    chk("R5 cr write clears aas", status, 8'h83);
    sr_write(8'h00);
    addr_match = 1; rw_bit = 1; step();
    chk("R5/R11 slave tx match, no iif", status, 8'hC5);
    cr_wr = 1; addr_match = 1; rw_bit = 1; step();
    chk("R5 match beats cr write", status, 8'hC5);
    cr_wr = 1; step();
  endtask

  task automatic t_arb_tx();
    mst_mode = 1; tx_mode = 1;
    bit_smp = 1; bit_cnt = 3; sda_drv = 0; sda_in = 0; step();
    chk("R6 no loss when driving low", status, 8'h85);
    bit_smp = 1; bit_cnt = 3; sda_drv = 1; sda_in = 0; step();
    chk("R6 tx mismatch", status, 8'h97);
    sr_write(8'hFF);
    chk("R10 write ones keeps flags", status, 8'h97);
    sr_write(8'hED);
    chk("R10 write zero clears al/iif", status, 8'h85);
  endtask

  task automatic t_arb_ack();
    mst_mode = 1; tx_mode = 0;
    bit_smp = 1; bit_cnt = 9; sda_drv = 1; sda_in = 0; step();
    chk("R7 ack slot mismatch", status, 8'h97);
    sr_write(8'h00);
  endtask

  task automatic t_arb_req();
    mst_mode = 1;
    ev_start = 1; step();
    req_start = 1; step();
    chk("R8 start while busy", status, 8'hB7);
    sr_write(8'h00);
    ev_stop = 1; stop_req = 1; step();
    chk("R9 requested stop no loss", status, 8'h85);
    req_start = 1; step();
    chk("R8 start while idle no loss", status, 8'h85);
    mst_mode = 0; req_rstart = 1; step();
    chk("R8 rstart in slave", status, 8'h97);
    sr_write(8'h00);
  endtask

  task automatic t_arb_stop();
    mst_mode = 1;
    ev_start = 1; step();
    ev_stop = 1; stop_req = 0; step();
    chk("R9 unrequested stop", status, 8'h97);
    sr_write(8'h00);
  endtask

  task automatic t_setwins();
    mst_mode = 1; tx_mode = 1;
    bit_smp = 1; bit_cnt = 2; sda_drv = 1; sda_in = 0;
    sr_wr = 1; sr_wdata = 8'h00; step();
    chk("R13 set beats clear", status, 8'h97);
    sr_write(8'h00);
    chk("R10 later clear works", status, 8'h85);
  endtask

  initial begin
    idle(); mst_mode = 0; tx_mode = 0; ien = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_byte();
    t_busy();
    t_slave();
    t_arb_tx();
    t_arb_ack();
    t_arb_req();
    t_arb_stop();
    t_setwins();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule